// File: doc/BRIEF.md
# Serial Character Transmitter with Per-Frame Format Selection

This block sends one character at a time on a single output line that stays high when idle. For every character the caller picks the frame format on the same cycle as the start strobe. The choices are one of four bit rates, seven or eight data bits, a parity bit that can be left out or set to odd or even, and one or two stop bits. The block latches those choices together with the character, so they may change freely while a frame is on the line.

The bit period is worked out at elaboration time from the system clock frequency, with one period per rate code. A single down-counter times every bit of the frame. A one-hot-free shift register, padded with ones, supplies the line level. The busy output tells the caller when the next strobe will be taken.

Top module: `serial_char_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `busy` is 0 and `txd` is 1.
- R2: `rate_sel` picks the bit rate: 0 gives BASE_BAUD (9600 by default), 1 gives half of it, 2 a quarter and 3 an eighth. The bit period is CLK_HZ divided by the rate, rounded to the nearest whole number of clock cycles.
- R3: A frame opens with one low start bit, followed by the data bits with bit 0 first.
- R4: With `len8` = 1, eight data bits (`char_in[7:0]`) are sent. With `len8` = 0, seven bits (`char_in[6:0]`) are sent and `char_in[7]` has no effect on the line.
- R5: With parity on, one parity bit follows the last data bit. If `par_even` = 1 it equals the XOR of the data bits sent; if `par_even` = 0 it is that XOR inverted.
- R6: With `par_on` = 0 no parity bit is sent, and the first stop bit follows the last data bit directly.
- R7: Stop bits are high. `stop2` = 0 sends one stop bit and `stop2` = 1 sends two.
- R8: Every bit of the frame (start, data, parity, stop) holds `txd` for exactly one bit period of the selected rate.
- R9: `busy` rises on the clock edge that accepts `start`, together with the start bit. It falls exactly at the end of the last stop bit, and a strobe on the next cycle starts a new frame at once.
- R10: A `start` strobe while `busy` is 1 is ignored: the running frame, including its format, is unchanged, and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a frame when idle |
| char_in | input | 8 | Character to send |
| rate_sel | input | 2 | Bit rate code |
| len8 | input | 1 | 1 = eight data bits, 0 = seven |
| par_on | input | 1 | 1 = send a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| stop2 | input | 1 | 1 = two stop bits, 0 = one |
| busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial line, idle high |

## Verification
A strobe taken at clock edge N shows up on the line after that same edge. `busy` is 1 and `txd` carries the start bit from there. Each following bit boundary falls exactly one divisor later, and `busy` is already 0 one cycle after the last stop-bit cycle. The driver turns every accepted character into a list of (level, cycle count) items. The monitor samples on falling clock edges. Starting with the first falling edge at which `busy` is high, it checks each item for exactly its cycle count and then checks `busy` low on the falling edge that follows. The bench runs at 100 kHz of nominal clock frequency, so two of the four divisors round upward (21 and 42) and a truncating divisor would be caught.

// File: rtl/serial_char_tx.sv
`timescale 1ns/1ps
module serial_char_tx #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BASE_BAUD = 9600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] char_in,
  input  logic [1:0] rate_sel,
  input  logic       len8,
  input  logic       par_on,
  input  logic       par_even,
  input  logic       stop2,
  output logic       busy,
  output logic       txd
);
  localparam int B0   = BASE_BAUD;
  localparam int B1   = BASE_BAUD / 2;
  localparam int B2   = BASE_BAUD / 4;
  localparam int B3   = BASE_BAUD / 8;
  localparam int DIV0 = (CLK_HZ + B0 / 2) / B0;
  localparam int DIV1 = (CLK_HZ + B1 / 2) / B1;
  localparam int DIV2 = (CLK_HZ + B2 / 2) / B2;
  localparam int DIV3 = (CLK_HZ + B3 / 2) / B3;
  localparam int CW   = $clog2(DIV3 + 1);
  localparam int FW   = 12;

  logic [CW-1:0] per_sel, per_q, cnt;
  logic [FW-1:0] shreg, frame;
  logic [3:0]    left, len_m1;
  logic [7:0]    payload;
  logic          pbit;

  always_comb begin
    case (rate_sel)
      2'd0:    per_sel = CW'(DIV0 - 1);
      2'd1:    per_sel = CW'(DIV1 - 1);
      2'd2:    per_sel = CW'(DIV2 - 1);
      default: per_sel = CW'(DIV3 - 1);
    endcase
  end

  assign payload = len8 ? char_in : {1'b0, char_in[6:0]};
  assign pbit    = par_on ? (^payload ^ ~par_even) : 1'b1;
  assign frame   = len8 ? {2'b11, pbit, char_in, 1'b0}
                        : {3'b111, pbit, char_in[6:0], 1'b0};
  assign len_m1  = 4'd8 + {3'b0, len8} + {3'b0, par_on} + {3'b0, stop2};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
      cnt   <= '0;
      per_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        shreg <= frame;
        left  <= len_m1;
        cnt   <= per_sel;
        per_q <= per_sel;
      end
    end else if (cnt == '0) begin
      if (left == '0) begin
        busy <= 1'b0;
      end else begin
        shreg <= {1'b1, shreg[FW-1:1]};
        left  <= left - 4'd1;
        cnt   <= per_q;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign txd = busy ? shreg[0] : 1'b1;

  AST_LAUNCH:     assert property (@(posedge clk) disable iff (rst) start && !busy |=> busy && !txd); // R9
  AST_START_LOW:  assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !txd); // R3
  AST_HOLD_BIT:   assert property (@(posedge clk) disable iff (rst) busy && cnt != '0 |=> busy && $stable(txd)); // R8
  AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (rst) busy |-> cnt <= per_q); // R8
  AST_STOP_HIGH:  assert property (@(posedge clk) disable iff (rst) busy && left == '0 |-> txd); // R7
  AST_FRAME_END:  assert property (@(posedge clk) disable iff (rst) busy && cnt == '0 && left == '0 |=> !busy && txd); // R9
  AST_FMT_LOCKED: assert property (@(posedge clk) disable iff (rst) busy && start |=> $stable(per_q)); // R10
endmodule

// File: tb/sim_serial_char_tx.sv
`timescale 1ns/1ps
module sim_serial_char_tx;
  logic clk = 0, rst = 1, start = 0;
  logic [7:0] char_in = 0;
  logic [1:0] rate_sel = 0;
  logic len8 = 0, par_on = 0, par_even = 0, stop2 = 0;
  logic busy, txd;
  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct { bit lvl; int len; bit last; string tag; } item_t;
  item_t q[$];
  int divs[4] = '{10, 21, 42, 83};

  serial_char_tx #(.CLK_HZ(100_000), .BASE_BAUD(9600)) u0 (
    .clk(clk), .rst(rst), .start(start), .char_in(char_in), .rate_sel(rate_sel),
    .len8(len8), .par_on(par_on), .par_even(par_even), .stop2(stop2),
    .busy(busy), .txd(txd));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input [7:0] ch, input [1:0] rc, input bit e8, input bit pe,
                      input bit pev, input bit s2);
    int d, n;
    bit p;
    item_t it;
    while (busy) @(negedge clk);
    d = divs[rc];
    n = e8 ? 8 : 7;
    q.push_back('{1'b0, d, 1'b0, "R3 start (R2 R8)"});
    p = 0;
    for (int i = 0; i < n; i++) begin
      q.push_back('{ch[i], d, 1'b0, "R4 data (R3 R8)"});
      p ^= ch[i];
    end
    if (pe) q.push_back('{pev ? p : ~p, d, 1'b0, "R5 parity (R8)"});
    it = '{1'b1, d, !s2, pe ? "R7 stop (R8)" : "R6 stop after data (R7)"};
    q.push_back(it);
    if (s2) q.push_back('{1'b1, d, 1'b1, "R7 second stop"});
    char_in = ch; rate_sel = rc; len8 = e8; par_on = pe; par_even = pev; stop2 = s2;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic poke(input [7:0] ch);
    char_in = ch; rate_sel = 2'd3; len8 = 1; par_on = 1; par_even = 0; stop2 = 1;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (!rst && busy) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected frame", busy, 0);
        end else begin
          it = q.pop_front();
          for (int k = 0; k < it.len; k++) begin
            if (k > 0) @(negedge clk);
            chk(busy === 1'b1 && txd === it.lvl, it.tag, {busy, txd}, {1'b1, it.lvl});
          end
          if (it.last) begin
            @(negedge clk);
            chk(busy === 1'b0, "R9 busy falls at frame end", busy, 0);
            chk(txd === 1'b1, "R1 idle high after frame", txd, 1);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy === 1'b0, "R1 reset busy", busy, 0);
    chk(txd === 1'b1, "R1 reset txd", txd, 1);
    send(8'hA5, 2'd0, 1, 1, 1, 0);
    send(8'h3C, 2'd1, 1, 1, 0, 1);
    send(8'hFF, 2'd2, 0, 1, 1, 0);
    send(8'h80, 2'd3, 0, 0, 0, 0);
    send(8'h5A, 2'd0, 1, 0, 0, 1);
    send(8'h01, 2'd1, 0, 1, 0, 1);
    send(8'h12, 2'd0, 1, 1, 1, 0);
    repeat (15) @(negedge clk);
    poke(8'hC3);
    repeat (60) @(negedge clk);
    poke(8'h0F);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (200) @(negedge clk);
    chk(busy === 1'b0 && txd === 1'b1, "R10 no frame from ignored strobe", {busy, txd}, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule